// File: doc/BRIEF.md
# Two-Channel Coincidence Pulse Processor

This block turns two asynchronous detector discriminator levels into clean, clock-aligned event signals. Both inputs pass through a synchronizer. A non-retriggerable one-shot then converts each rising edge into a fixed-width pulse, and that pulse is exported as the channel's discriminator output.

The two shaped pulses are combined in two ways. Their AND marks a coincidence and their XOR marks an anti-coincidence. Each result is stretched by a retriggerable timer to a longer pulse for a host GPIO. Each shaped pulse is also stretched to a very long pulse that can drive a visible indicator LED.

A registered five-way selector drives one timing output, which feeds an external edge timestamper. The selector chooses between both discriminator outputs, both event outputs and a synchronized external time pulse. All widths are parameters counted in clock cycles. At 100 MHz they are 10, 100 and 10,000,000 cycles.

Top module: `coinc_pulse_proc`

## Requirements
- R1: While `rst_n` is low, every output (`disc_out`, `coinc_out`, `anti_out`, `led_out`, `time_out`) is 0.
- R2: A 0-to-1 transition on `det_in[i]` that is first sampled high at clock edge k makes `disc_out[i]` rise at edge k+2 and stay high for exactly SHAPE_CYC cycles.
- R3: A rising input edge that reaches the one-shot while `disc_out[i]` is high is ignored and does not lengthen the pulse. An input held high yields a single pulse.
- R4: `coinc_out` rises one clock after the first cycle in which both `disc_out` bits are high. It stays high until EVT_CYC cycles after the last such cycle.
- R5: `anti_out` rises one clock after the first cycle in which exactly one `disc_out` bit is high. It stays high until EVT_CYC cycles after the last such cycle.
- R6: A new coincidence or anti-coincidence while the matching output is still high reloads its timer to the full EVT_CYC, so two close events give one unbroken output pulse.
- R7: `led_out[i]` rises one clock after `disc_out[i]` rises. It stays high until LED_CYC cycles after the last cycle in which `disc_out[i]` was high.
- R8: `time_out` is a register. At each edge it takes the source chosen by `tsel` before that edge: code 0 `disc_out[0]`, 1 `disc_out[1]`, 2 `coinc_out`, 3 `anti_out`, 4 the synchronized `tp_in`.
- R9: Select codes 5 to 15 drive `time_out` to 0, whatever the state of the sources.
- R10: `tp_in` passes through a two-flop synchronizer. A level first sampled at edge k appears on `time_out` at edge k+2 when code 4 is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_in | input | 2 | Asynchronous discriminator levels, one per channel |
| tp_in | input | 1 | Asynchronous external time pulse |
| tsel | input | 4 | Timing output source select code |
| disc_out | output | 2 | Shaped discriminator pulses |
| coinc_out | output | 1 | Stretched coincidence event |
| anti_out | output | 1 | Stretched anti-coincidence event |
| led_out | output | 2 | Long per-channel indicator pulses |
| time_out | output | 1 | Registered, glitch-free timing output |

## Verification
A one-shot counter that is off by one shows at once as a discriminator pulse one cycle too short or too long. A one-shot that wrongly accepts a second edge shows as a pulse longer than SHAPE_CYC. A wrong stretcher reload rule appears as a gap in `coinc_out` or `anti_out`, or as a pulse of the wrong length. That error becomes visible EVT_CYC cycles after the event, and LED_CYC cycles later for the indicator. A selector or synchronizer fault makes `time_out` disagree with its chosen source one or two clocks after an edge. The bench compares every output on every cycle against its own per-cycle model, so any of these faults is caught within the window named above.

// File: rtl/pp_pkg.sv
`timescale 1ns/1ps
package pp_pkg;

  localparam int unsigned N_SRC = 5;

  typedef enum logic [3:0] {
    TSEL_DISC_A = 4'd0,
    TSEL_DISC_B = 4'd1,
    TSEL_COINC  = 4'd2,
    TSEL_ANTI   = 4'd3,
    TSEL_EXT    = 4'd4
  } tsel_e;

  // one-shot: loads only from idle on an edge, otherwise counts down
  function automatic int unsigned os_next(int unsigned cur, logic hit, int unsigned width);
    if (cur == 0 && hit) return width;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

  // stretcher: every trigger cycle reloads the full width
  function automatic int unsigned st_next(int unsigned cur, logic trig, int unsigned width);
    if (trig) return width;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

  // selector: legal codes index the source vector, others give 0
  function automatic logic sel_pick(logic [3:0] sel, logic [N_SRC-1:0] src);
    if (sel < 4'(N_SRC)) return src[sel[2:0]];
    return 1'b0;
  endfunction

endpackage

// File: rtl/pp_sync.sv
`timescale 1ns/1ps
module pp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pp_oneshot.sv
`timescale 1ns/1ps
module pp_oneshot #(
  parameter int unsigned WIDTH = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse,
  output logic rise
);
  localparam int unsigned CW = $clog2(WIDTH + 1);

  logic          lvl_q;
  logic [CW-1:0] cnt_q;

  assign rise  = lvl & ~lvl_q;
  assign pulse = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl;
      cnt_q <= CW'(pp_pkg::os_next(32'(cnt_q), rise, WIDTH));
    end
  end

  // R2: an edge from idle starts a full-width pulse
  a_r2_start_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !pulse) |=> (cnt_q == CW'(WIDTH)));

  // R3: while active, edges do not reload; count strictly falls
  a_r3_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && cnt_q != CW'(1)) |=> (pulse && cnt_q == $past(cnt_q) - CW'(1)));

  a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(WIDTH));
endmodule

// File: rtl/pp_stretch.sv
`timescale 1ns/1ps
module pp_stretch #(
  parameter int unsigned WIDTH = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic out
);
  localparam int unsigned CW = $clog2(WIDTH + 1);

  logic [CW-1:0] cnt_q;

  assign out = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CW'(pp_pkg::st_next(32'(cnt_q), trig, WIDTH));
  end

  // R6: any trigger reloads to the full width
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (out && cnt_q == CW'(WIDTH)));

  // R6: without a trigger the output only decays
  a_r6_decay: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && out) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !out) |=> !out);
endmodule

// File: rtl/pp_tsel_mux.sv
`timescale 1ns/1ps
module pp_tsel_mux (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [3:0]              sel,
  input  logic [pp_pkg::N_SRC-1:0] src,
  output logic                    tout
);
  logic tout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tout_q <= 1'b0;
    else        tout_q <= pp_pkg::sel_pick(sel, src);
  end

  assign tout = tout_q;

  // R8: each legal code routes its source with one register of delay
  generate
    for (genvar i = 0; i < int'(pp_pkg::N_SRC); i++) begin : g_route_chk
      a_r8_route: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 4'(i)) |=> (tout == $past(src[i])));
    end
  endgenerate

  // R9: unused codes hold the output low
  a_r9_unused_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sel >= 4'(pp_pkg::N_SRC)) |=> !tout);
endmodule

// File: rtl/coinc_pulse_proc.sv
`timescale 1ns/1ps
module coinc_pulse_proc #(
  parameter int unsigned SHAPE_CYC   = 10,
  parameter int unsigned EVT_CYC     = 100,
  parameter int unsigned LED_CYC     = 10_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] det_in,
  input  logic       tp_in,
  input  logic [3:0] tsel,
  output logic [1:0] disc_out,
  output logic       coinc_out,
  output logic       anti_out,
  output logic [1:0] led_out,
  output logic       time_out
);
  localparam int unsigned N_CH = 2;

  logic [N_CH-1:0] det_s;
  logic [N_CH-1:0] shaped;
  logic [N_CH-1:0] edge_seen;
  logic            both_on;
  logic            one_on;
  logic            tp_s;
  logic [pp_pkg::N_SRC-1:0] tsrc;

  generate
    for (genvar c = 0; c < int'(N_CH); c++) begin : g_ch
      pp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(det_in[c]), .q(det_s[c]));

      pp_oneshot #(.WIDTH(SHAPE_CYC)) u_shape (
        .clk(clk), .rst_n(rst_n), .lvl(det_s[c]),
        .pulse(shaped[c]), .rise(edge_seen[c]));

      pp_stretch #(.WIDTH(LED_CYC)) u_led (
        .clk(clk), .rst_n(rst_n), .trig(shaped[c]), .out(led_out[c]));

      // R7: indicator follows its shaped pulse one clock later
      a_r7_led_follows: assert property (@(posedge clk) disable iff (!rst_n)
        shaped[c] |=> led_out[c]);
    end
  endgenerate

  assign both_on = shaped[0] & shaped[1];
  assign one_on  = shaped[0] ^ shaped[1];

  pp_stretch #(.WIDTH(EVT_CYC)) u_coinc (
    .clk(clk), .rst_n(rst_n), .trig(both_on), .out(coinc_out));

  pp_stretch #(.WIDTH(EVT_CYC)) u_anti (
    .clk(clk), .rst_n(rst_n), .trig(one_on), .out(anti_out));

  pp_sync #(.STAGES(SYNC_STAGES)) u_tp_sync (
    .clk(clk), .rst_n(rst_n), .d(tp_in), .q(tp_s));

  assign tsrc[pp_pkg::TSEL_DISC_A] = shaped[0];
  assign tsrc[pp_pkg::TSEL_DISC_B] = shaped[1];
  assign tsrc[pp_pkg::TSEL_COINC]  = coinc_out;
  assign tsrc[pp_pkg::TSEL_ANTI]   = anti_out;
  assign tsrc[pp_pkg::TSEL_EXT]    = tp_s;

  pp_tsel_mux u_tsel (
    .clk(clk), .rst_n(rst_n), .sel(tsel), .src(tsrc), .tout(time_out));

  assign disc_out = shaped;

  // R4: overlap of both shaped pulses raises the coincidence output
  a_r4_coinc: assert property (@(posedge clk) disable iff (!rst_n)
    both_on |=> coinc_out);

  // R5: exactly one shaped pulse raises the anti-coincidence output
  a_r5_anti: assert property (@(posedge clk) disable iff (!rst_n)
    one_on |=> anti_out);

  // R4: no coincidence output can start without an overlap
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!coinc_out && !both_on) |=> !coinc_out);

  // R1: immediately after reset release everything is quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!coinc_out && !anti_out && disc_out == 2'b00));
endmodule

// File: tb/tb_coinc_pulse_proc.sv
`timescale 1ns/1ps
module tb_coinc_pulse_proc;
  localparam int SH = 10;
  localparam int EV = 40;
  localparam int LD = 300;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] det_in;
  logic       tp_in;
  logic [3:0] tsel;
  logic [1:0] disc_out;
  logic       coinc_out, anti_out, time_out;
  logic [1:0] led_out;

  always #2.5 clk = ~clk;

  coinc_pulse_proc #(.SHAPE_CYC(SH), .EVT_CYC(EV), .LED_CYC(LD)) dut (
    .clk(clk), .rst_n(rst_n), .det_in(det_in), .tp_in(tp_in), .tsel(tsel),
    .disc_out(disc_out), .coinc_out(coinc_out), .anti_out(anti_out),
    .led_out(led_out), .time_out(time_out));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state, from the requirements
  int m_os[2];
  int m_led[2];
  int m_co, m_an;
  bit m_h1[2], m_h2[2], m_h3[2];
  bit e_h1, e_h2;
  bit m_tout;
  int m_sel_used;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int c = 0; c < 2; c++) begin
      m_os[c] = 0; m_led[c] = 0;
      m_h1[c] = 0; m_h2[c] = 0; m_h3[c] = 0;
    end
    m_co = 0; m_an = 0; e_h1 = 0; e_h2 = 0; m_tout = 0; m_sel_used = 0;
  endfunction

  // one clock edge of the reference, using values seen before the edge
  function automatic void model_edge(bit x0, bit x1, bit ext, int sel);
    bit d0 = (m_os[0] > 0);
    bit d1 = (m_os[1] > 0);
    bit [4:0] srcs = {e_h2, (m_an > 0), (m_co > 0), d1, d0};
    m_tout = (sel < 5) ? srcs[sel] : 1'b0;
    m_sel_used = sel;
    m_co = (d0 && d1) ? EV : ((m_co > 0) ? m_co - 1 : 0);
    m_an = (d0 != d1) ? EV : ((m_an > 0) ? m_an - 1 : 0);
    m_led[0] = d0 ? LD : ((m_led[0] > 0) ? m_led[0] - 1 : 0);
    m_led[1] = d1 ? LD : ((m_led[1] > 0) ? m_led[1] - 1 : 0);
    for (int c = 0; c < 2; c++) begin
      if (m_os[c] > 0) m_os[c] = m_os[c] - 1;
      else if (m_h2[c] && !m_h3[c]) m_os[c] = SH;
    end
    m_h3[0] = m_h2[0]; m_h2[0] = m_h1[0]; m_h1[0] = x0;
    m_h3[1] = m_h2[1]; m_h2[1] = m_h1[1]; m_h1[1] = x1;
    e_h2 = e_h1; e_h1 = ext;
  endfunction

  task automatic compare_all();
    string ttag;
    chk("R2 disc_out[0]", disc_out[0], m_os[0] > 0);
    chk("R2 disc_out[1]", disc_out[1], m_os[1] > 0);
    chk("R4 coinc_out", coinc_out, m_co > 0);
    chk("R5 anti_out", anti_out, m_an > 0);
    chk("R7 led_out[0]", led_out[0], m_led[0] > 0);
    chk("R7 led_out[1]", led_out[1], m_led[1] > 0);
    if (m_sel_used >= 5)      ttag = "R9 time_out";
    else if (m_sel_used == 4) ttag = "R10 time_out";
    else                      ttag = "R8 time_out";
    chk(ttag, time_out, m_tout);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge(det_in[0], det_in[1], tp_in, int'(tsel));
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic pick_out(int which);
    case (which)
      0: return disc_out[0];
      1: return disc_out[1];
      2: return coinc_out;
      3: return anti_out;
      4: return led_out[0];
      5: return led_out[1];
      default: return time_out;
    endcase
  endfunction

  task automatic observe(input int n, input int which, inout int highs, inout int rises);
    logic prev = pick_out(which);
    for (int i = 0; i < n; i++) begin
      step();
      if (pick_out(which)) highs++;
      if (pick_out(which) && !prev) rises++;
      prev = pick_out(which);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int h, r;
    void'($urandom(32'd4711));
    rst_n = 1'b0; det_in = 2'b00; tp_in = 1'b0; tsel = 4'd0;
    model_clear();
    repeat (4) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 disc_out[0]", disc_out[0], 1'b0);
    chk("R1 disc_out[1]", disc_out[1], 1'b0);
    chk("R1 coinc_out", coinc_out, 1'b0);
    chk("R1 anti_out", anti_out, 1'b0);
    chk("R1 led_out", |led_out, 1'b0);
    chk("R1 time_out", time_out, 1'b0);
    rst_n = 1'b1;
    idle(5);

    // R2 / R3: held-high input gives one pulse of SHAPE_CYC cycles
    det_in[0] = 1'b1; h = 0; r = 0;
    observe(80, 0, h, r);
    chk_int("R2 held pulse width", h, SH);
    chk_int("R3 held pulse count", r, 1);
    det_in[0] = 1'b0;
    idle(LD + 40);

    // R3: second edge during the active pulse is ignored
    h = 0; r = 0;
    det_in[0] = 1'b1; observe(2, 0, h, r);
    det_in[0] = 1'b0; observe(2, 0, h, r);
    det_in[0] = 1'b1; observe(60, 0, h, r);
    chk_int("R3 re-edge width", h, SH);
    chk_int("R3 re-edge count", r, 1);
    det_in[0] = 1'b0;
    idle(LD + 40);

    // R4 / R6: two coincidences 35 cycles apart merge into one pulse
    h = 0; r = 0;
    det_in = 2'b11; observe(5, 2, h, r);
    det_in = 2'b00; observe(30, 2, h, r);
    det_in = 2'b11; observe(120, 2, h, r);
    chk_int("R6 coinc merged width", h, 35 + SH + EV - 1);
    chk_int("R6 coinc single rise", r, 1);
    det_in = 2'b00;
    idle(LD + 40);

    // R5: channels 20 cycles apart give anti only, no coincidence
    h = 0; r = 0;
    begin
      int hc = 0, rc = 0;
      det_in = 2'b01; observe(3, 3, h, r);
      det_in = 2'b00; observe(17, 3, h, r);
      det_in = 2'b10; observe(3, 3, h, r);
      det_in = 2'b00; observe(100, 3, h, r);
      chk_int("R5 anti merged width", h, 20 + SH + EV - 1);
      chk_int("R5 anti single rise", r, 1);
      observe(1, 2, hc, rc);
      chk_int("R4 no coinc without overlap", rc, 0);
    end
    idle(LD + 40);

    // R7: indicator length
    h = 0; r = 0;
    det_in[1] = 1'b1; observe(3, 5, h, r);
    det_in[1] = 1'b0; observe(LD + 80, 5, h, r);
    chk_int("R7 led width", h, SH + LD - 1);
    chk_int("R7 led rise", r, 1);

    // R9: unused codes keep time_out low with active sources
    h = 0; r = 0;
    tsel = 4'd9; tp_in = 1'b1; det_in = 2'b11;
    observe(40, 6, h, r);
    tsel = 4'd15; det_in = 2'b00;
    observe(40, 6, h, r);
    chk_int("R9 unused codes low", h, 0);
    tp_in = 1'b0;

    // R10 / R8: external pulse latency through code 4
    tsel = 4'd4; idle(4);
    tp_in = 1'b1;
    step();
    chk("R10 not yet (edge k)", time_out, 1'b0);
    step();
    chk("R10 not yet (edge k+1)", time_out, 1'b0);
    step();
    chk("R10 arrives (edge k+2)", time_out, 1'b1);
    tp_in = 1'b0; idle(LD + 20);

    // random traffic against the reference
    for (int cyc = 0; cyc < 15000; cyc++) begin
      if ($urandom % 14 == 0) det_in[0] = ~det_in[0];
      if ($urandom % 14 == 0) det_in[1] = ~det_in[1];
      if ($urandom % 9 == 0)  tp_in = ~tp_in;
      if ($urandom % 150 == 0) tsel = 4'($urandom % 16);
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule